// File: doc/BRIEF.md
# Serial Port Clock and Data Path Router

This block holds the 8-bit control word of a serial port and turns it into routing decisions. One field chooses the role of a shared clock pin; other fields choose where the receiver clock comes from and what drives the baud generator. Two further fields, echo and loopback, choose how the serial data pins, the transmit shift output and the receiver data input are connected. The clock divisor and stick parity fields are decoded and passed on to the transmitter and receiver. The baud generator divider is not part of this block.

The word is written through a simple register port. A write enable with data loads the word on the next clock edge, and the current word is always presented on the read data output. Clocks are treated as ordinary signals and routed combinationally, so a selected clock appears at its destination with no register delay. Interrupt logic is never gated by this block, so transmit and receive interrupts keep working in loopback.

Top module: `sio_clk_router`

## Requirements
- R1: After reset the control word reads 00h: the clock pin is general I/O with the output enable low, the receiver clock and transmit clock come from the baud generator output, the baud generator source is the internal clock, the data output pin follows the transmit shift output and the receiver data input follows the input data pin.
- R2: When the write enable is high on a rising clock edge, the write data becomes the control word after that edge and reads back unchanged. When the write enable is low, the control word keeps its value whatever the write data.
- R3: Bits 7:6 of the control word set the clock pin role. 00: the pin output carries the general I/O data input. 01: the pin is a transmit clock input and its output is 0. 10: the pin output carries the baud generator output. 11: the pin output carries the synchronous-mode clock. The pin output enable is high only for codes 10 and 11.
- R4: The transmit clock is the clock pin input when bits 7:6 are 01, and the baud generator output for every other code.
- R5: When bit 5 is 1 the receiver clock is the external receive clock; when it is 0 the receiver clock is the baud generator output and the external receive clock has no effect on it.
- R6: When bit 4 is 0 the baud generator source output is the internal clock; when it is 1 it is the external receive clock.
- R7: When bit 2 (echo) is 1 and bit 1 (loopback) is 0, the data output pin equals the input data pin, the transmit shift output has no effect on it, and the receiver data input equals the input data pin.
- R8: When bit 1 (loopback) is 1 and bit 2 is 0, the data output pin is held at 1, the receiver data input equals the transmit shift output, and the input data pin has no effect on either.
- R9: When bits 2 and 1 are both 1, the data output pin equals the input data pin and the receiver data input equals the transmit shift output.
- R10: The divide-by-one output equals bit 3 of the control word and the stick parity output equals bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write enable |
| cfg_wdata_i | input | 8 | Control word write data |
| cfg_rdata_o | output | 8 | Control word read data |
| int_clk_i | input | 1 | Internal clock |
| ext_rx_clk_i | input | 1 | External receive clock |
| txclk_pin_i | input | 1 | Clock pin input value |
| brg_clk_i | input | 1 | Baud generator output clock |
| sync_clk_i | input | 1 | Synchronous/expansion mode clock |
| gpio_dout_i | input | 1 | General I/O data for the clock pin |
| tx_shift_i | input | 1 | Transmit shift register output |
| sdin_i | input | 1 | Input data pin |
| tx_clk_o | output | 1 | Selected transmitter clock |
| rx_clk_o | output | 1 | Selected receiver clock |
| brg_src_o | output | 1 | Clock that feeds the baud generator |
| clk_pin_o | output | 1 | Clock pin output value |
| clk_pin_oe_o | output | 1 | Clock pin output enable |
| sdout_o | output | 1 | Output data pin |
| rx_data_o | output | 1 | Receiver serial data input |
| div1x_o | output | 1 | One clock per bit mode |
| stick_par_o | output | 1 | Stick parity enable |

## Verification
The bench builds the block with its default reset value of 00h, which makes the reset state the general I/O, internal-source, straight-through configuration checked first. From there, control words that isolate each field and words that combine echo with loopback are written, and after each one a sweep of input combinations toggles every clock and data input independently. The sweep shows both that each selected source reaches its output and that every unselected source leaves the outputs unchanged, while writes with the enable low confirm the word holds.

// File: rtl/sio_router_pkg.sv
package sio_router_pkg;

  typedef enum logic [1:0] {
    PIN_GPIO     = 2'b00,
    PIN_TXCLK_IN = 2'b01,
    PIN_BRG_OUT  = 2'b10,
    PIN_SYNC_OUT = 2'b11
  } pin_role_e;

  // Field order is fixed: software encodes the word this way.
  typedef struct packed {
    pin_role_e role;
    logic      rx_ext;
    logic      brg_ext;
    logic      div1x;
    logic      echo;
    logic      loop;
    logic      stick_par;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);

endpackage

// File: rtl/sio_ctl_reg.sv
module sio_ctl_reg #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST_VAL;
    else if (we_i) q <= wdata_i;
  end

  assign q_o = q;

  AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(wdata_i)));  // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));  // R2

endmodule

// File: rtl/sio_clk_select.sv
module sio_clk_select
  import sio_router_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pin_role_e role_i,
  input  logic      rx_ext_i,
  input  logic      brg_ext_i,
  input  logic      int_clk_i,
  input  logic      ext_rx_clk_i,
  input  logic      txclk_pin_i,
  input  logic      brg_clk_i,
  input  logic      sync_clk_i,
  input  logic      gpio_dout_i,
  output logic      tx_clk_o,
  output logic      rx_clk_o,
  output logic      brg_src_o,
  output logic      clk_pin_o,
  output logic      clk_pin_oe_o
);

  always_comb begin
    clk_pin_o    = 1'b0;
    clk_pin_oe_o = 1'b0;
    unique case (role_i)
      PIN_GPIO:     clk_pin_o = gpio_dout_i;
      PIN_TXCLK_IN: clk_pin_o = 1'b0;
      PIN_BRG_OUT: begin
        clk_pin_o    = brg_clk_i;
        clk_pin_oe_o = 1'b1;
      end
      PIN_SYNC_OUT: begin
        clk_pin_o    = sync_clk_i;
        clk_pin_oe_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign tx_clk_o  = (role_i == PIN_TXCLK_IN) ? txclk_pin_i : brg_clk_i;
  assign rx_clk_o  = rx_ext_i  ? ext_rx_clk_i : brg_clk_i;
  assign brg_src_o = brg_ext_i ? ext_rx_clk_i : int_clk_i;

  AST_OE_ONLY_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (role_i == PIN_GPIO || role_i == PIN_TXCLK_IN) |-> !clk_pin_oe_o);  // R3
  AST_TXCLK_FROM_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (role_i == PIN_TXCLK_IN) |-> (tx_clk_o == txclk_pin_i));  // R4
  AST_RXCLK_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ext_i |-> (rx_clk_o == ext_rx_clk_i));  // R5
  AST_BRG_INTERNAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brg_ext_i |-> (brg_src_o == int_clk_i));  // R6

endmodule

// File: rtl/sio_data_route.sv
module sio_data_route (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic echo_i,
  input  logic loop_i,
  input  logic tx_shift_i,
  input  logic sdin_i,
  output logic sdout_o,
  output logic rx_data_o
);

  // Echo owns the output pin; loopback owns the receiver input.
  always_comb begin
    if (echo_i)      sdout_o = sdin_i;
    else if (loop_i) sdout_o = 1'b1;
    else             sdout_o = tx_shift_i;
  end

  assign rx_data_o = loop_i ? tx_shift_i : sdin_i;

  AST_ECHO_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    echo_i |-> (sdout_o == sdin_i));  // R7
  AST_LOOP_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_i && !echo_i) |-> sdout_o);  // R8
  AST_LOOP_RX_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_i |-> (rx_data_o == tx_shift_i));  // R9
  AST_PLAIN_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_i |-> (rx_data_o == sdin_i));  // R7

endmodule

// File: rtl/sio_clk_router.sv
module sio_clk_router
  import sio_router_pkg::*;
#(
  parameter logic [CTL_W-1:0] CTL_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CTL_W-1:0] cfg_wdata_i,
  output logic [CTL_W-1:0] cfg_rdata_o,
  input  logic             int_clk_i,
  input  logic             ext_rx_clk_i,
  input  logic             txclk_pin_i,
  input  logic             brg_clk_i,
  input  logic             sync_clk_i,
  input  logic             gpio_dout_i,
  input  logic             tx_shift_i,
  input  logic             sdin_i,
  output logic             tx_clk_o,
  output logic             rx_clk_o,
  output logic             brg_src_o,
  output logic             clk_pin_o,
  output logic             clk_pin_oe_o,
  output logic             sdout_o,
  output logic             rx_data_o,
  output logic             div1x_o,
  output logic             stick_par_o
);

  logic [CTL_W-1:0] ctl_q;
  ctl_t             ctl;

  sio_ctl_reg #(.W(CTL_W), .RST_VAL(CTL_RST)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .q_o     (ctl_q)
  );

  assign ctl         = ctl_t'(ctl_q);
  assign cfg_rdata_o = ctl_q;
  assign div1x_o     = ctl.div1x;
  assign stick_par_o = ctl.stick_par;

  sio_clk_select u_clk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .role_i       (ctl.role),
    .rx_ext_i     (ctl.rx_ext),
    .brg_ext_i    (ctl.brg_ext),
    .int_clk_i    (int_clk_i),
    .ext_rx_clk_i (ext_rx_clk_i),
    .txclk_pin_i  (txclk_pin_i),
    .brg_clk_i    (brg_clk_i),
    .sync_clk_i   (sync_clk_i),
    .gpio_dout_i  (gpio_dout_i),
    .tx_clk_o     (tx_clk_o),
    .rx_clk_o     (rx_clk_o),
    .brg_src_o    (brg_src_o),
    .clk_pin_o    (clk_pin_o),
    .clk_pin_oe_o (clk_pin_oe_o)
  );

  sio_data_route u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .echo_i     (ctl.echo),
    .loop_i     (ctl.loop),
    .tx_shift_i (tx_shift_i),
    .sdin_i     (sdin_i),
    .sdout_o    (sdout_o),
    .rx_data_o  (rx_data_o)
  );

  AST_DIV_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (div1x_o == $past(cfg_wdata_i[3])));  // R10
  AST_STICK_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (stick_par_o == $past(cfg_wdata_i[0])));  // R10

endmodule

// File: tb/sio_clk_router_test.sv
module sio_clk_router_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_ni;
  logic       we;
  logic [7:0] wdata;
  logic [7:0] pins;  // {int,ext_rx,txpin,brg,sync,tx_shift,sdin,gpio}
  logic [7:0] rdata;
  logic tx_clk, rx_clk, brg_src, pin_o, pin_oe, sdout, rx_data, div1x, stick;

  sio_clk_router uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata),
    .int_clk_i(pins[7]), .ext_rx_clk_i(pins[6]), .txclk_pin_i(pins[5]),
    .brg_clk_i(pins[4]), .sync_clk_i(pins[3]), .tx_shift_i(pins[2]),
    .sdin_i(pins[1]), .gpio_dout_i(pins[0]),
    .tx_clk_o(tx_clk), .rx_clk_o(rx_clk), .brg_src_o(brg_src),
    .clk_pin_o(pin_o), .clk_pin_oe_o(pin_oe), .sdout_o(sdout),
    .rx_data_o(rx_data), .div1x_o(div1x), .stick_par_o(stick)
  );

  typedef struct {
    logic [16:0] v;
    string       tag;
  } item_t;

  item_t      exp_q[$];
  int         errors = 0;
  int         checks = 0;
  logic [7:0] model_cfg = 8'h00;
  bit         done = 0;

  function automatic logic [16:0] model(input logic [7:0] c, input logic [7:0] p);
    logic t, r, b, po, oe, so, rd;
    t  = (c[7:6] == 2'b01) ? p[5] : p[4];
    r  = c[5] ? p[6] : p[4];
    b  = c[4] ? p[6] : p[7];
    case (c[7:6])
      2'b00:   po = p[0];
      2'b01:   po = 1'b0;
      2'b10:   po = p[4];
      default: po = p[3];
    endcase
    oe = c[7];
    so = c[2] ? p[1] : (c[1] ? 1'b1 : p[2]);
    rd = c[1] ? p[2] : p[1];
    return {c, t, r, b, po, oe, so, rd, c[3], c[0]};
  endfunction

  task automatic check_now(input logic [16:0] e, input string tag);
    logic [16:0] a;
    a = {rdata, tx_clk, rx_clk, brg_src, pin_o, pin_oe, sdout, rx_data, div1x, stick};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual=%05h expected=%05h (cfg=%02h pins=%02h)",
               tag, a, e, model_cfg, pins);
    end
  endtask

  task automatic drive(input logic w, input logic [7:0] d, input logic [7:0] p,
                       input string tag);
    item_t it;
    @(negedge clk);
    we    = w;
    wdata = d;
    pins  = p;
    if (w) model_cfg = d;
    it.v   = model(model_cfg, p);
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: pops one expected item per cycle, after the register edge settles.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        check_now(it.v, it.tag);
      end
    end
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [7:0] cfgs [12];
  string      tags [12];

  initial begin
    cfgs[0]  = 8'h00; tags[0]  = "R1";
    cfgs[1]  = 8'h08; tags[1]  = "R10";
    cfgs[2]  = 8'h01; tags[2]  = "R10";
    cfgs[3]  = 8'h40; tags[3]  = "R4";
    cfgs[4]  = 8'h80; tags[4]  = "R3";
    cfgs[5]  = 8'hC0; tags[5]  = "R3";
    cfgs[6]  = 8'h20; tags[6]  = "R5";
    cfgs[7]  = 8'h10; tags[7]  = "R6";
    cfgs[8]  = 8'h04; tags[8]  = "R7";
    cfgs[9]  = 8'h02; tags[9]  = "R8";
    cfgs[10] = 8'h06; tags[10] = "R9";
    cfgs[11] = 8'hFF; tags[11] = "R2";

    rst_ni = 1'b0;
    we     = 1'b0;
    wdata  = 8'hA5;
    pins   = 8'h00;
    #5;
    check_now(model(8'h00, 8'h00), "R1 reset");
    pins = 8'h06;
    #1;
    check_now(model(8'h00, 8'h06), "R1 reset");
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < 12; i++) begin
      drive(1'b1, cfgs[i], 8'h00, "R2 write");
      for (int k = 0; k < 32; k++) begin
        // Write data differs from the word with the enable low: must be held.
        drive(1'b0, ~cfgs[i], 8'((k * 37 + i * 11 + 5) & 8'hFF), tags[i]);
      end
    end

    wait (exp_q.size() == 0);
    @(posedge clk);
    #5;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule